// File: doc/BRIEF.md
# Timestamp-Priority Concentrated Crossbar

This block moves flit descriptors between the nodes of a network simulator. Nodes are split into partitions, and each partition has a single path into the crossbar and a single path out of it. In every cycle, a first arbiter inside each partition picks one pending flit from that partition's nodes. A second arbiter at each destination partition then settles contention among the partitions that target it. Both arbiters favour the flit that is due earliest. Simulated time therefore advances in order even though each partition can only move one flit per cycle.

A node presents a valid flag, a descriptor and a destination node index. Its grant output is combinational in the same cycle. A node that is not granted keeps its request and descriptor unchanged until it is granted. One cycle after the grant, the winning descriptor appears on the delivery outputs of the destination node. The credit network is a second instance of the same block with a narrower descriptor width.

Top module: `tsx_xbar`

## Requirements
- R1: Node n belongs to partition n mod NUM_PARTS and has local index n div NUM_PARTS in that partition. A destination index uses the same mapping, so the low PART_W bits select the partition and the upper bits select the local node.
- R2: In any cycle, at most one node of a given source partition receives a grant.
- R3: In any cycle, at most one node of a given destination partition has its delivery valid asserted.
- R4: The timestamp field is descriptor bits [TS_LSB+2:TS_LSB], which is [2:0] by default. The priority key is (timestamp − now_ts) mod 8, and within a partition the smallest key wins. The modulo makes the order correct across the wrap from 7 to 0.
- R5: At each destination partition, the same smallest-key rule chooses among the candidates of the source partitions that target it.
- R6: When keys are equal, the candidate with the lowest node index wins, at both stages.
- R7: A flit granted in cycle t is delivered in cycle t+1. Its delivery valid is asserted only at its destination node, and its descriptor is unchanged.
- R8: Grants go only to nodes whose valid is asserted. The number of deliveries in a cycle equals the number of grants in the previous cycle.
- R9: While rst_n is low, no grant is issued. After reset, all delivery valids are low.
- R10: Every destination partition that is targeted by at least one partition candidate accepts exactly one flit in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ts | input | 3 | Current simulation time modulo 8 |
| in_valid | input | NUM_NODES | Per-node request |
| in_desc | input | NUM_NODES×DESC_W | Per-node flit descriptor |
| in_dst | input | NUM_NODES×NODE_W | Per-node destination node index |
| in_grant | output | NUM_NODES | Per-node grant, same cycle as the request |
| out_valid | output | NUM_NODES | Per-node delivery valid |
| out_desc | output | NUM_NODES×DESC_W | Per-node delivered descriptor |

## Verification
The random traffic uses about half-loaded requests with random destinations and a random current time. Flits that lose arbitration are held, so losers build up and the same partition and destination sets compete again under different time offsets. This separates the two-stage selection from any single-stage shortcut. Directed cases isolate four behaviours: a cross-partition delivery that exposes the round-robin node mapping, a wrap-around pair where the raw timestamp order and the modular order disagree, a pair where the destination stage picks the earlier partition candidate, and exact ties that only the node index resolves.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
   localparam int TS_W = 3;

   // distance of a timestamp ahead of the current time, modulo 2**TS_W
   function automatic logic [TS_W-1:0] ts_key(input logic [TS_W-1:0] ts,
                                              input logic [TS_W-1:0] now);
      return ts - now;
   endfunction
endpackage

// File: rtl/tsx_min_sel.sv
module tsx_min_sel #(
   parameter int ENTRIES = 2,
   parameter int KEY_W   = 3,
   parameter int IDX_W   = 4,
   localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0]            req,
   input  logic [ENTRIES-1:0][KEY_W-1:0] key,
   input  logic [ENTRIES-1:0][IDX_W-1:0] idx,
   output logic                          any,
   output logic [SEL_W-1:0]              sel
);
   logic [KEY_W-1:0] best_key;
   logic [IDX_W-1:0] best_idx;

   // linear scan: smallest key, then smallest index
   always_comb begin
      any      = 1'b0;
      sel      = '0;
      best_key = '0;
      best_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (req[i] && (!any || key[i] < best_key ||
                        (key[i] == best_key && idx[i] < best_idx))) begin
            any      = 1'b1;
            sel      = SEL_W'(i);
            best_key = key[i];
            best_idx = idx[i];
         end
      end
   end
endmodule

// File: rtl/tsx_deliver.sv
module tsx_deliver #(
   parameter int DESC_W        = 32,
   parameter int NODES_PER_PART = 2,
   localparam int LOC_W        = $clog2(NODES_PER_PART)
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   take,
   input  logic [DESC_W-1:0]                      take_desc,
   input  logic [LOC_W-1:0]                       take_loc,
   output logic [NODES_PER_PART-1:0]              dv,
   output logic [NODES_PER_PART-1:0][DESC_W-1:0]  dd
);
   logic              hold_v;
   logic [DESC_W-1:0] hold_d;
   logic [LOC_W-1:0]  hold_l;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
         hold_l <= '0;
      end else begin
         hold_v <= take;
         if (take) begin
            hold_d <= take_desc;
            hold_l <= take_loc;
         end
      end
   end

   for (genvar j = 0; j < NODES_PER_PART; j++) begin : g_node
      assign dv[j] = hold_v && (hold_l == LOC_W'(j));
      assign dd[j] = hold_d;
   end

   assert_one_delivery_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dv));
endmodule

// File: rtl/tsx_xbar.sv
module tsx_xbar
   import tsx_pkg::*;
#(
   parameter int NUM_PARTS      = 8,
   parameter int NODES_PER_PART = 2,
   parameter int DESC_W         = 32,
   parameter int TS_LSB         = 0,
   localparam int NUM_NODES     = NUM_PARTS * NODES_PER_PART,
   localparam int PART_W        = $clog2(NUM_PARTS),
   localparam int LOC_W         = $clog2(NODES_PER_PART),
   localparam int NODE_W        = PART_W + LOC_W
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [TS_W-1:0]                      now_ts,
   input  logic [NUM_NODES-1:0]                 in_valid,
   input  logic [NUM_NODES-1:0][DESC_W-1:0]     in_desc,
   input  logic [NUM_NODES-1:0][NODE_W-1:0]     in_dst,
   output logic [NUM_NODES-1:0]                 in_grant,
   output logic [NUM_NODES-1:0]                 out_valid,
   output logic [NUM_NODES-1:0][DESC_W-1:0]     out_desc
);
   if (NUM_PARTS < 2 || (NUM_PARTS & (NUM_PARTS - 1)) != 0) begin : g_bad_parts
      $error("NUM_PARTS must be a power of two, at least 2");
   end
   if (NODES_PER_PART < 2 || (NODES_PER_PART & (NODES_PER_PART - 1)) != 0) begin : g_bad_npp
      $error("NODES_PER_PART must be a power of two, at least 2");
   end
   if (DESC_W < TS_LSB + TS_W) begin : g_bad_desc
      $error("DESC_W too narrow for the timestamp field");
   end

   // stage 1 results, one candidate per source partition
   logic [NUM_PARTS-1:0]                 s1_any;
   logic [NUM_PARTS-1:0][LOC_W-1:0]      s1_sel;
   logic [NUM_PARTS-1:0][NODE_W-1:0]     cand_node;
   logic [NUM_PARTS-1:0][TS_W-1:0]       cand_key;
   logic [NUM_PARTS-1:0][DESC_W-1:0]     cand_desc;
   logic [NUM_PARTS-1:0][NODE_W-1:0]     cand_dst;
   // stage 2 results, one winner per destination partition
   logic [NUM_PARTS-1:0][NUM_PARTS-1:0]  s2_req;
   logic [NUM_PARTS-1:0]                 s2_any;
   logic [NUM_PARTS-1:0][PART_W-1:0]     s2_sel;
   logic [NUM_PARTS-1:0][NODES_PER_PART-1:0]             dv;
   logic [NUM_PARTS-1:0][NODES_PER_PART-1:0][DESC_W-1:0] dd;
   logic [NUM_PARTS-1:0][NODES_PER_PART-1:0]             gp;

   for (genvar p = 0; p < NUM_PARTS; p++) begin : g_src
      logic [NODES_PER_PART-1:0]             req;
      logic [NODES_PER_PART-1:0][TS_W-1:0]   key;
      logic [NODES_PER_PART-1:0][NODE_W-1:0] idx;
      for (genvar j = 0; j < NODES_PER_PART; j++) begin : g_mem
         localparam int NODE = j * NUM_PARTS + p;
         assign req[j]  = in_valid[NODE];
         assign key[j]  = ts_key(in_desc[NODE][TS_LSB +: TS_W], now_ts);
         assign idx[j]  = NODE_W'(NODE);
         assign gp[p][j] = in_grant[NODE];
      end
      tsx_min_sel #(.ENTRIES(NODES_PER_PART), .KEY_W(TS_W), .IDX_W(NODE_W)) u_part (
         .req(req), .key(key), .idx(idx), .any(s1_any[p]), .sel(s1_sel[p]));
      assign cand_node[p] = {s1_sel[p], PART_W'(p)};
      assign cand_key[p]  = key[s1_sel[p]];
      assign cand_desc[p] = in_desc[cand_node[p]];
      assign cand_dst[p]  = in_dst[cand_node[p]];

      assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gp[p]));
   end

   for (genvar q = 0; q < NUM_PARTS; q++) begin : g_dst
      for (genvar p = 0; p < NUM_PARTS; p++) begin : g_req
         assign s2_req[q][p] = s1_any[p] && (cand_dst[p][PART_W-1:0] == PART_W'(q));
      end
      tsx_min_sel #(.ENTRIES(NUM_PARTS), .KEY_W(TS_W), .IDX_W(NODE_W)) u_dest (
         .req(s2_req[q]), .key(cand_key), .idx(cand_node),
         .any(s2_any[q]), .sel(s2_sel[q]));
      tsx_deliver #(.DESC_W(DESC_W), .NODES_PER_PART(NODES_PER_PART)) u_out (
         .clk(clk), .rst_n(rst_n), .take(s2_any[q] && rst_n),
         .take_desc(cand_desc[s2_sel[q]]),
         .take_loc(cand_dst[s2_sel[q]][NODE_W-1:PART_W]),
         .dv(dv[q]), .dd(dd[q]));
      for (genvar j = 0; j < NODES_PER_PART; j++) begin : g_map
         assign out_valid[j * NUM_PARTS + q] = dv[q][j];
         assign out_desc[j * NUM_PARTS + q]  = dd[q][j];
      end

      assert_dest_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (|s2_req[q]) |-> s2_any[q]);
   end

   // a source partition is granted when some destination chose it
   always_comb begin
      in_grant = '0;
      for (int p = 0; p < NUM_PARTS; p++) begin
         logic won;
         won = 1'b0;
         for (int q = 0; q < NUM_PARTS; q++) begin
            if (s2_any[q] && s2_sel[q] == PART_W'(p)) won = 1'b1;
         end
         if (won && rst_n) in_grant[cand_node[p]] = 1'b1;
      end
   end

   assert_grant_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_grant & ~in_valid) == '0);
   assert_delivery_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_valid) == $past($countones(in_grant)));
endmodule

// File: tb/sim_tsx_xbar.sv
`timescale 1ns/1ps
module sim_tsx_xbar;
   localparam int P  = 8;
   localparam int NPP = 2;
   localparam int N  = P * NPP;
   localparam int NW = 4;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] now;
   logic [N-1:0] v;
   logic [N-1:0][DW-1:0] d;
   logic [N-1:0][NW-1:0] dst;
   logic [N-1:0] grant, ov;
   logic [N-1:0][DW-1:0] od;

   logic [N-1:0] exp_g, exp_ov;
   logic [N-1:0][DW-1:0] exp_od;
   int checks = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   tsx_xbar u0 (.clk(clk), .rst_n(rst_n), .now_ts(now), .in_valid(v),
      .in_desc(d), .in_dst(dst), .in_grant(grant), .out_valid(ov), .out_desc(od));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int key_of(input logic [DW-1:0] desc, input logic [2:0] t);
      return int'(3'(desc[2:0] - t));
   endfunction

   // expected grants and next-cycle deliveries from the requirements
   task automatic model();
      int cand [P];
      exp_g = '0; exp_ov = '0; exp_od = '0;
      for (int p = 0; p < P; p++) begin
         cand[p] = -1;
         for (int j = 0; j < NPP; j++) begin
            int n = j * P + p;
            if (v[n] && (cand[p] < 0 || key_of(d[n], now) < key_of(d[cand[p]], now)))
               cand[p] = n;
         end
      end
      for (int q = 0; q < P; q++) begin
         int w = -1;
         for (int p = 0; p < P; p++) begin
            if (cand[p] >= 0 && int'(dst[cand[p]]) % P == q) begin
               if (w < 0 || key_of(d[cand[p]], now) < key_of(d[w], now) ||
                   (key_of(d[cand[p]], now) == key_of(d[w], now) && cand[p] < w))
                  w = cand[p];
            end
         end
         if (w >= 0) begin
            exp_g[w] = 1'b1;
            exp_ov[dst[w]] = 1'b1;
            exp_od[dst[w]] = d[w];
         end
      end
   endtask

   // inputs already driven after a falling edge
   task automatic step(input string tag);
      #1;
      model();
      chk(grant == exp_g, {"R2 R4 R5 R6 R10 grant ", tag}, 64'(grant), 64'(exp_g));
      @(posedge clk); #1;
      chk(ov == exp_ov, {"R3 R8 delivery ", tag}, 64'(ov), 64'(exp_ov));
      for (int n = 0; n < N; n++)
         if (exp_ov[n]) chk(od[n] == exp_od[n], {"R7 descriptor ", tag}, 64'(od[n]), 64'(exp_od[n]));
      @(negedge clk);
   endtask

   task automatic clear();
      v = '0; d = '0; dst = '0; now = '0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      clear();
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         v = N'($urandom()); 
         for (int n = 0; n < N; n++) begin d[n] = $urandom(); dst[n] = NW'($urandom()); end
         #1;
         chk(grant == '0, "R9 no grant in reset", 64'(grant), 64'h0);
         @(negedge clk);
      end
      clear();
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(ov == '0, "R9 outputs idle after reset", 64'(ov), 64'h0);
      @(negedge clk);

      // R1: node 1 (partition 1) to node 9 (partition 1, local 1)
      clear(); v[1] = 1'b1; d[1] = 32'hA5A5_0003; dst[1] = 4'd9;
      #1;
      chk(grant == 16'h0002, "R1 grant node 1", 64'(grant), 64'h2);
      @(posedge clk); #1;
      chk(ov == 16'h0200, "R1 delivered at node 9", 64'(ov), 64'h200);
      chk(od[9] == 32'hA5A5_0003, "R7 descriptor at node 9", 64'(od[9]), 64'hA5A50003);
      @(negedge clk);

      // R4 wrap: now 6, ts 7 (key 1) beats ts 1 (key 3) in partition 0
      clear(); now = 3'd6;
      v[0] = 1'b1; d[0] = 32'h0000_0011; dst[0] = 4'd3;
      v[8] = 1'b1; d[8] = 32'h0000_0027; dst[8] = 4'd5;
      #1;
      chk(grant == 16'h0100, "R4 wrap order", 64'(grant), 64'h100);
      step("R4 wrap");

      // R5: partitions 2 and 3 target partition 0; ts 2 beats ts 4
      clear();
      v[2] = 1'b1; d[2] = 32'h0000_0004; dst[2] = 4'd0;
      v[3] = 1'b1; d[3] = 32'h0000_0002; dst[3] = 4'd8;
      #1;
      chk(grant == 16'h0008, "R5 destination order", 64'(grant), 64'h8);
      step("R5");

      // R6 ties: nodes 4 and 12 share partition 4; node 5 ties at destination
      clear();
      v[4] = 1'b1;  d[4] = 32'h0000_0103;  dst[4] = 4'd6;
      v[12] = 1'b1; d[12] = 32'h0000_0203; dst[12] = 4'd7;
      v[5] = 1'b1;  d[5] = 32'h0000_0303;  dst[5] = 4'd14;
      #1;
      chk(grant == 16'h0010, "R6 lowest index wins ties", 64'(grant), 64'h10);
      step("R6");

      // random traffic; losers hold their request unchanged
      clear();
      for (int it = 0; it < 400; it++) begin
         now = 3'($urandom());
         for (int n = 0; n < N; n++) begin
            if (!v[n] || grant[n]) begin
               v[n] = ($urandom() % 2) == 0;
               d[n] = $urandom();
               dst[n] = NW'($urandom());
            end
         end
         step("random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule